// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block holds the fetch address of a multicycle processor and computes its next value. On each falling clock edge on which the external controller raises the load enable, the counter takes one of three candidate addresses. The first is the next sequential word. The second is a PC-relative branch target built from a signed 16-bit word offset. The third is a region-local jump target built from a 26-bit word index. The fourth select code leaves the counter unchanged.

The branch and jump constants come straight from the instruction word. The block scales them to byte addresses and sign-extends the branch offset. The controller decides whether a branch is taken and when to load. The address is always word aligned: its two lowest bits are wired to zero and are not stored. A jump replaces only the low 28 bits and keeps the top four bits of the current address, so it stays inside the current 256 MiB region.

Top module: `pc_next_unit`

## Requirements
- R1: While `load_en` is 0 (and `rst` is 0), `fetch_addr` keeps its value across a falling edge, whatever `src_sel`, `br_imm` and `jmp_imm` carry.
- R2: With `load_en` = 1 and `src_sel` = 2'b00, the next `fetch_addr` is the current value plus 4, wrapping modulo 2^32.
- R3: With `load_en` = 1 and `src_sel` = 2'b01, the next `fetch_addr` is the current value plus `br_imm` sign-extended from bit 15 and multiplied by 4. The offset is relative to the current value, not to the current value plus 4.
- R4: With `load_en` = 1 and `src_sel` = 2'b10, bits 27..2 of the next `fetch_addr` take `jmp_imm`, bits 1..0 are 0, and bits 31..28 keep their current value.
- R5: With `load_en` = 1 and `src_sel` = 2'b11, `fetch_addr` keeps its value.
- R6: Bits 1..0 of `fetch_addr` read 0 at all times.
- R7: `rst` is synchronous and active high. When it is sampled high on a falling edge, `fetch_addr` becomes 0, taking priority over `load_en`.
- R8: `fetch_addr` changes only on the falling edge of `clk`. It is unchanged across a rising edge, even when the inputs change there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state updates on its falling edge |
| rst | input | 1 | Synchronous active-high reset to address 0 |
| load_en | input | 1 | Load enable from the controller |
| src_sel | input | 2 | Next-address source: 00 sequential, 01 branch, 10 jump, 11 hold |
| br_imm | input | 16 | Signed word offset from the instruction word |
| jmp_imm | input | 26 | Word index for a jump from the instruction word |
| fetch_addr | output | 32 | Current fetch address to memory |

## Verification
Each result is due at the first falling edge after the inputs are driven, because the only register between the inputs and `fetch_addr` is clocked on that edge. The bench drives inputs just after a rising edge and reads the old address again before the falling edge to confirm that nothing has moved (R8). It then reads the new address one time unit after the falling edge and compares it with the value its own model computes. Long positive and negative branch offsets place the address near the top of the space, so wrap-around and the preserved jump region bits are exercised.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  typedef enum logic [1:0] {
    SRC_SEQ  = 2'b00,
    SRC_BR   = 2'b01,
    SRC_JMP  = 2'b10,
    SRC_HOLD = 2'b11
  } pc_src_e;

  localparam int unsigned SRC_COUNT = 4;

endpackage

// File: rtl/pcu_target_calc.sv
module pcu_target_calc #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned BR_W   = 16,
  parameter int unsigned J_W    = 26,
  parameter int unsigned ALIGN  = 2
) (
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic [BR_W-1:0]   br_imm,
  input  logic [J_W-1:0]    jmp_imm,
  output logic [ADDR_W-1:0] seq_pc,
  output logic [ADDR_W-1:0] br_pc,
  output logic [ADDR_W-1:0] jmp_pc
);

  localparam int unsigned JSPAN  = J_W + ALIGN;
  localparam int unsigned SEXT_W = ADDR_W - BR_W - ALIGN;

  // next word: adder with a single constant bit at the alignment position
  function automatic logic [ADDR_W-1:0] f_seq(input logic [ADDR_W-1:0] pc);
    logic [ADDR_W-1:0] stride;
    stride        = '0;
    stride[ALIGN] = 1'b1;
    return pc + stride;
  endfunction

  // relative target: sign-extended word offset scaled to bytes
  function automatic logic [ADDR_W-1:0] f_branch(input logic [ADDR_W-1:0] pc,
                                                 input logic [BR_W-1:0]   off);
    logic [ADDR_W-1:0] bytes;
    bytes = {{SEXT_W{off[BR_W-1]}}, off, {ALIGN{1'b0}}};
    return pc + bytes;
  endfunction

  // region-local target: upper region bits of the current address kept
  function automatic logic [ADDR_W-1:0] f_jump(input logic [ADDR_W-1:0] pc,
                                               input logic [J_W-1:0]    idx);
    return {pc[ADDR_W-1:JSPAN], idx, {ALIGN{1'b0}}};
  endfunction

  always_comb begin
    seq_pc = f_seq(cur_pc);
    br_pc  = f_branch(cur_pc, br_imm);
    jmp_pc = f_jump(cur_pc, jmp_imm);
  end

endmodule

// File: rtl/pcu_src_mux.sv
module pcu_src_mux #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [1:0]        sel,
  input  logic [ADDR_W-1:0] seq_pc,
  input  logic [ADDR_W-1:0] br_pc,
  input  logic [ADDR_W-1:0] jmp_pc,
  input  logic [ADDR_W-1:0] cur_pc,
  output logic [ADDR_W-1:0] next_pc
);

  import pcu_pkg::*;

  logic [ADDR_W-1:0] cand [SRC_COUNT];
  logic [SRC_COUNT-1:0] hit;

  assign cand[SRC_SEQ]  = seq_pc;
  assign cand[SRC_BR]   = br_pc;
  assign cand[SRC_JMP]  = jmp_pc;
  assign cand[SRC_HOLD] = cur_pc;

  for (genvar g = 0; g < SRC_COUNT; g++) begin : g_hit
    assign hit[g] = (sel == g[1:0]);
  end

  always_comb begin
    next_pc = '0;
    for (int i = 0; i < SRC_COUNT; i++) begin
      if (hit[i]) next_pc = next_pc | cand[i];
    end
  end

endmodule

// File: rtl/pcu_pc_reg.sv
module pcu_pc_reg #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned ALIGN  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] d,
  output logic [ADDR_W-1:0] q
);

  localparam int unsigned STORE_W = ADDR_W - ALIGN;

  logic [STORE_W-1:0] hi_q;

  // only the word-address bits are flops; state moves on the falling edge
  always_ff @(negedge clk) begin
    if (rst)          hi_q <= '0;
    else if (load_en) hi_q <= d[ADDR_W-1:ALIGN];
  end

  assign q = {hi_q, {ALIGN{1'b0}}};

  assert_reset_clears_R7: assert property (@(negedge clk)
    rst |=> (q == '0));

  assert_disabled_holds_R1: assert property (@(negedge clk) disable iff (rst)
    !load_en |=> $stable(q));

endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned BR_W   = 16,
  parameter int unsigned J_W    = 26,
  parameter int unsigned ALIGN  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [1:0]        src_sel,
  input  logic [BR_W-1:0]   br_imm,
  input  logic [J_W-1:0]    jmp_imm,
  output logic [ADDR_W-1:0] fetch_addr
);

  import pcu_pkg::*;

  localparam int unsigned JSPAN = J_W + ALIGN;

  logic [ADDR_W-1:0] seq_pc, br_pc, jmp_pc, next_pc;

  // named events for the checks below
  logic take_seq, take_br, take_jmp, take_hold;
  assign take_seq  = load_en && (src_sel == SRC_SEQ);
  assign take_br   = load_en && (src_sel == SRC_BR);
  assign take_jmp  = load_en && (src_sel == SRC_JMP);
  assign take_hold = load_en && (src_sel == SRC_HOLD);

  pcu_target_calc #(
    .ADDR_W(ADDR_W), .BR_W(BR_W), .J_W(J_W), .ALIGN(ALIGN)
  ) u_calc (
    .cur_pc (fetch_addr),
    .br_imm (br_imm),
    .jmp_imm(jmp_imm),
    .seq_pc (seq_pc),
    .br_pc  (br_pc),
    .jmp_pc (jmp_pc)
  );

  pcu_src_mux #(.ADDR_W(ADDR_W)) u_mux (
    .sel    (src_sel),
    .seq_pc (seq_pc),
    .br_pc  (br_pc),
    .jmp_pc (jmp_pc),
    .cur_pc (fetch_addr),
    .next_pc(next_pc)
  );

  pcu_pc_reg #(.ADDR_W(ADDR_W), .ALIGN(ALIGN)) u_reg (
    .clk    (clk),
    .rst    (rst),
    .load_en(load_en),
    .d      (next_pc),
    .q      (fetch_addr)
  );

  assert_seq_step_R2: assert property (@(negedge clk) disable iff (rst)
    take_seq |=> (fetch_addr - $past(fetch_addr) == ADDR_W'(4)));

  assert_jump_keeps_region_R4: assert property (@(negedge clk) disable iff (rst)
    take_jmp |=> (fetch_addr[ADDR_W-1:JSPAN] == $past(fetch_addr[ADDR_W-1:JSPAN])));

  assert_hold_code_R5: assert property (@(negedge clk) disable iff (rst)
    take_hold |=> $stable(fetch_addr));

  assert_branch_low_bits_R6: assert property (@(negedge clk) disable iff (rst)
    take_br |=> (fetch_addr[ALIGN-1:0] == '0));

endmodule

// File: tb/pc_next_unit_test.sv
module pc_next_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam int RAND_STEPS = 400;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_en = 1'b0;
  logic [1:0]  src_sel = 2'b00;
  logic [15:0] br_imm = '0;
  logic [25:0] jmp_imm = '0;
  logic [31:0] fetch_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] expv = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_next_unit uut (
    .clk(clk), .rst(rst), .load_en(load_en), .src_sel(src_sel),
    .br_imm(br_imm), .jmp_imm(jmp_imm), .fetch_addr(fetch_addr)
  );

  function automatic logic [31:0] model(input logic [31:0] pc, input logic r,
                                        input logic le, input logic [1:0] s,
                                        input logic [15:0] bi, input logic [25:0] ji);
    int signed off;
    if (r) return 32'h0;
    if (!le) return pc;
    case (s)
      2'b00: return pc + 32'd4;
      2'b01: begin
        off = int'($signed(bi)) * 4;
        return pc + 32'(off);
      end
      2'b10: return (pc & 32'hF000_0000) | (32'(ji) << 2);
      default: return pc;
    endcase
  endfunction

  function automatic string tag_of(input logic r, input logic le, input logic [1:0] s);
    if (r) return "R7";
    if (!le) return "R1";
    case (s)
      2'b00: return "R2";
      2'b01: return "R3";
      2'b10: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic le, input logic [1:0] s,
                      input logic [15:0] bi, input logic [25:0] ji, input bit edge_chk);
    logic [31:0] nexp;
    @(posedge clk);
    #1;
    rst = r; load_en = le; src_sel = s; br_imm = bi; jmp_imm = ji;
    nexp = model(expv, r, le, s, bi, ji);
    #1;
    if (edge_chk) check(fetch_addr === expv, "R8", fetch_addr, expv);
    @(negedge clk);
    #1;
    check(fetch_addr === nexp, tag_of(r, le, s), fetch_addr, nexp);
    check(fetch_addr[1:0] === 2'b00, "R6", {30'd0, fetch_addr[1:0]}, 32'd0);
    expv = nexp;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%08h expected=%08h", fetch_addr, expv);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // reset state R7, with load requested at the same time
    step(1'b1, 1'b1, 2'b00, 16'h0, 26'h0, 1'b0);
    step(1'b1, 1'b1, 2'b10, 16'h0, 26'h3FF_FFFF, 1'b0);
    // R2 sequential steps, with R8 rising-edge stability
    step(1'b0, 1'b1, 2'b00, 16'h0, 26'h0, 1'b1);
    step(1'b0, 1'b1, 2'b00, 16'h0, 26'h0, 1'b1);
    // R3 branch relative to current value, positive then negative
    step(1'b0, 1'b1, 2'b01, 16'h0003, 26'h0, 1'b1);
    step(1'b0, 1'b1, 2'b01, 16'hFFFF, 26'h0, 1'b1);
    step(1'b0, 1'b1, 2'b01, 16'h8000, 26'h0, 1'b0);   // address now in top region
    // R4 jump keeps the upper four bits
    step(1'b0, 1'b1, 2'b10, 16'h0, 26'h3FF_FFFF, 1'b1);
    // R2 wrap from the last word to zero
    step(1'b0, 1'b1, 2'b00, 16'h0, 26'h0, 1'b0);
    step(1'b0, 1'b1, 2'b01, 16'h8000, 26'h0, 1'b0);
    step(1'b0, 1'b1, 2'b10, 16'h0, 26'h000_0001, 1'b0);
    // R1 disabled load ignores every source; R5 hold code
    step(1'b0, 1'b0, 2'b00, 16'h7FFF, 26'h123_4567, 1'b1);
    step(1'b0, 1'b0, 2'b10, 16'h7FFF, 26'h123_4567, 1'b0);
    step(1'b0, 1'b1, 2'b11, 16'h7FFF, 26'h123_4567, 1'b1);
    step(1'b0, 1'b1, 2'b01, 16'h7FFF, 26'h0, 1'b0);
    // constrained random mix with a fixed seed
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < RAND_STEPS; i++) begin
      logic r, le;
      logic [1:0] s;
      r  = ($urandom % 40) == 0;
      le = ($urandom % 5) != 0;
      s  = 2'($urandom);
      step(r, le, s, 16'($urandom), 26'($urandom), (i % 7) == 0);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule